// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller organised as banks of 32 pins. Each bank exposes seven word registers: the sampled pin level, the pin direction, a write-one-to-set and a write-one-to-clear port for the output latch, per-pin rising and falling edge enables, and an edge status word whose bits are cleared by writing ones. Enabled edges seen on a pin are latched into its status bit. A single interrupt output is high whenever any status bit in any bank is set.

External pin inputs pass through a two-flop synchronizer before they reach the level register and the edge detectors. Banks 0 to 2 and banks 3 and up sit in two separate address windows. A build option gives a contiguous range of pins an inverted direction polarity. The last bank may be partly populated: its absent pins read as zero and ignore writes.

The register port is a plain single-cycle bus. A write is taken at the clock edge while the write enable is high. Read data is combinational from the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The byte address of a register is its register offset plus its bank offset. The register offsets are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rise-enable 0x30, fall-enable 0x3C, status 0x48. The bank offset is n*4 for banks 0 to 2 and 0x100 + (n-3)*4 for bank 3 and up. A write reaches exactly one register of one bank.
- R2: The level register returns, for each input pin, the pin value from two clock edges earlier, through the synchronizer. For each output pin it returns the value the pin is driving.
- R3: Writing a word to the set register drives high every output latch bit that has a 1 in that word. Writing a word to the clear register drives low every such bit. Bits written as 0 keep their value.
- R4: On a normal pin, direction bit 1 makes the pin an output: `pin_oe` is 1 and `pin_out` carries its output latch. Direction bit 0 makes it an input.
- R5: When `INV_EN` is 1, pins `INV_LO` to `INV_HI` use the opposite polarity: direction bit 0 means output and 1 means input. These pins are therefore outputs that drive 0 after reset.
- R6: A pin with its rise-enable bit set latches its status bit on a 0-to-1 change of its level.
- R7: A pin with its fall-enable bit set latches its status bit on a 1-to-0 change of its level. With both enables set, both kinds of change latch. With neither set, no change latches.
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If a newly detected edge and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `irq` is high exactly when at least one status bit in any bank is set.
- R10: Pins at or above `NUM_PINS` in the last bank read as zero in every register and ignore writes.
- R11: The set and clear registers read as zero, writes to the level register have no effect, and unmapped addresses read as zero and ignore writes.
- R12: The reset, synchronous and active low, clears every register, the synchronizer and the output latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write enable, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| irq | output | 1 | OR of all edge status bits |

## Verification
The hardest case to reach from the ports is a status bit that already holds an earlier edge, receiving a software clear in the very cycle a new edge on the same pin is latched. The bench reaches it by counting the synchronizer and detector registers: it toggles the pin on a falling clock edge and places the clear write so that the write lands on the third rising edge after that. It then checks that the bit survived, and checks that a clear with no edge present does remove the bit. The other parts of the bench sweep every pin of a partly populated four-bank build that includes an inverted range: each pin's rising and falling edge latching, the interrupt, and the single-bit clear are checked one pin at a time.

// File: rtl/pgc_pkg.sv
// Package: shared constants, register selector type and address helpers for
// the banked GPIO controller. Assumes 32-bit data words and byte addressing.
package pgc_pkg;

    localparam int WORD_W       = 32;
    localparam int NUM_REGS     = 7;
    localparam int REG_STRIDE   = 12;    // byte distance between register groups
    localparam int LOW_BANKS    = 3;     // banks packed in the first window
    localparam int HIGH_BASE    = 256;   // start of the second window
    localparam int MAX_BANKS    = 6;

    typedef enum logic [2:0] {
        REG_LEVEL = 3'd0,
        REG_DIR   = 3'd1,
        REG_SET   = 3'd2,
        REG_CLR   = 3'd3,
        REG_RISE  = 3'd4,
        REG_FALL  = 3'd5,
        REG_STAT  = 3'd6
    } reg_sel_e;

    // Byte offset of a bank inside its register group.
    function automatic int bank_offset(input int bank);
        if (bank < LOW_BANKS)
            return bank * 4;
        return HIGH_BASE + (bank - LOW_BANKS) * 4;
    endfunction

    // Byte address of register r of bank b.
    function automatic int reg_address(input int r, input int bank);
        return r * REG_STRIDE + bank_offset(bank);
    endfunction

endpackage

// File: rtl/pgc_sync.sv
// Module: two-flop synchronizer for the asynchronous pin inputs.
// Assumes each pin is independent; no multi-bit coherency is implied.
module pgc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two register stages; both clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/pgc_addr_dec.sv
// Module: address decoder for the split two-window bank layout. Compares the
// bus address against every register of every present bank and reports the
// matching bank and register. Assumes word-aligned accesses.
module pgc_addr_dec
    import pgc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_BANKS = 6,
    parameter int BANK_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BANK_W-1:0] bank,
    output reg_sel_e          rsel
);

    // Parallel compare against all mapped register addresses.
    always_comb begin
        hit  = 1'b0;
        bank = '0;
        rsel = REG_LEVEL;
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (addr == ADDR_W'(reg_address(r, b))) begin
                    hit  = 1'b1;
                    bank = BANK_W'(b);
                    rsel = reg_sel_e'(3'(r));
                end
            end
        end
    end

endmodule

// File: rtl/pgc_bank.sv
// Module: one 32-pin bank. Holds direction, output latch, edge enables and
// edge status. Computes the pin level, detects edges on it and applies
// set/clear and write-one-to-clear writes. Assumes pin_sync is already
// synchronized. Bits for absent pins are held at zero by constant masks.
module pgc_bank
    import pgc_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int NUM_PINS = 32,
    parameter int WIDTH    = 32,
    parameter bit INV_EN   = 1'b0,
    parameter int INV_LO   = 0,
    parameter int INV_HI   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          rsel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WORD_W-1:0] rd_data,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              stat_any
);

    function automatic logic [WORD_W-1:0] calc_exist();
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++)
            m[i] = (BANK_IDX * WORD_W + i) < NUM_PINS;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] calc_invert();
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++)
            m[i] = INV_EN && ((BANK_IDX * WORD_W + i) >= INV_LO)
                          && ((BANK_IDX * WORD_W + i) <= INV_HI)
                          && ((BANK_IDX * WORD_W + i) < NUM_PINS);
        return m;
    endfunction

    localparam logic [WORD_W-1:0] EXIST  = calc_exist();
    localparam logic [WORD_W-1:0] INVERT = calc_invert();

    logic [WORD_W-1:0] dir_q, out_q, rise_q, fall_q, stat_q, prev_q;
    logic [WORD_W-1:0] pin_w, oe_w, level_w, new_ev;
    logic [WORD_W-1:0] wdata_m, clr_mask;
    logic              wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_stat;

    // Write strobes per register of this bank.
    always_comb begin
        wr_dir  = wr_en && (rsel == REG_DIR);
        wr_set  = wr_en && (rsel == REG_SET);
        wr_clr  = wr_en && (rsel == REG_CLR);
        wr_rise = wr_en && (rsel == REG_RISE);
        wr_fall = wr_en && (rsel == REG_FALL);
        wr_stat = wr_en && (rsel == REG_STAT);
        wdata_m = wdata & EXIST;
        clr_mask = wr_stat ? wdata_m : '0;
    end

    // Effective direction, observed level and qualified edge events.
    always_comb begin
        pin_w   = WORD_W'(pin_sync);
        oe_w    = (dir_q ^ INVERT) & EXIST;
        level_w = ((oe_w & out_q) | (~oe_w & pin_w)) & EXIST;
        new_ev  = (((level_w & ~prev_q) & rise_q) |
                   ((~level_w & prev_q) & fall_q)) & EXIST;
    end

    // Register state: configuration, output latch, history and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
            prev_q <= '0;
        end else begin
            if (wr_dir)  dir_q  <= wdata_m;
            if (wr_rise) rise_q <= wdata_m;
            if (wr_fall) fall_q <= wdata_m;
            if (wr_set)
                out_q <= out_q | wdata_m;
            else if (wr_clr)
                out_q <= out_q & ~wdata_m;
            prev_q <= level_w;
            stat_q <= (stat_q & ~clr_mask) | new_ev;
        end
    end

    // Read multiplexer for the selected register.
    always_comb begin
        unique case (rsel)
            REG_LEVEL: rd_data = level_w;
            REG_DIR:   rd_data = dir_q;
            REG_RISE:  rd_data = rise_q;
            REG_FALL:  rd_data = fall_q;
            REG_STAT:  rd_data = stat_q;
            default:   rd_data = '0;
        endcase
    end

    assign pin_out  = out_q[WIDTH-1:0];
    assign pin_oe   = oe_w[WIDTH-1:0];
    assign stat_any = |stat_q;

    // R6 R7 R8: a qualified edge is in the status word one cycle later, even under a clear.
    assert_edge_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (new_ev != '0) |=> ((stat_q & $past(new_ev)) == $past(new_ev)));

    // R3: a set write raises every written bit of the latch.
    assert_set_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & $past(wdata_m)) == $past(wdata_m)));

    // R3: a clear write lowers every written bit of the latch.
    assert_clr_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_q & $past(wdata_m)) == '0));

    // R8: without edges or a status write, status holds.
    assert_stat_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stat && (new_ev == '0)) |=> $stable(stat_q));

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: top of the banked GPIO controller. Synchronizes the pins, decodes
// the bus address, instantiates one bank per 32 pins and combines the bank
// status into one interrupt. Assumes NUM_PINS is 1 to 192 and that ADDR_W
// covers the second address window.
module gpio_bank_ctrl
    import pgc_pkg::*;
#(
    parameter int NUM_PINS = 192,
    parameter int ADDR_W   = 12,
    parameter bit INV_EN   = 1'b0,
    parameter int INV_LO   = 86,
    parameter int INV_HI   = 89
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);

    localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [NUM_PINS-1:0]  sync_w;
    logic                 dec_hit;
    logic [BANK_W-1:0]    dec_bank;
    reg_sel_e             dec_rsel;
    logic [NUM_BANKS-1:0] bank_wr;
    logic [NUM_BANKS-1:0] bank_stat;
    logic [WORD_W-1:0]    bank_rd [NUM_BANKS];

    pgc_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_w)
    );

    pgc_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .bank (dec_bank),
        .rsel (dec_rsel)
    );

    // Route the write enable to the addressed bank only.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++)
            bank_wr[b] = bus_we && dec_hit && (dec_bank == BANK_W'(b));
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int W = ((NUM_PINS - b * WORD_W) >= WORD_W) ? WORD_W
                                                              : (NUM_PINS - b * WORD_W);
        pgc_bank #(
            .BANK_IDX (b),
            .NUM_PINS (NUM_PINS),
            .WIDTH    (W),
            .INV_EN   (INV_EN),
            .INV_LO   (INV_LO),
            .INV_HI   (INV_HI)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr[b]),
            .rsel     (dec_rsel),
            .wdata    (bus_wdata),
            .pin_sync (sync_w[b*WORD_W +: W]),
            .rd_data  (bank_rd[b]),
            .pin_out  (pin_out[b*WORD_W +: W]),
            .pin_oe   (pin_oe[b*WORD_W +: W]),
            .stat_any (bank_stat[b])
        );
    end

    // Return the addressed bank's register, zero when unmapped.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (dec_hit && (dec_bank == BANK_W'(b)))
                bus_rdata = bank_rd[b];
    end

    // Interrupt is the OR of all bank status words.
    assign irq = |bank_stat;

    // R1: at most one bank receives any write.
    assert_one_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr));

endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;

    localparam int NP   = 100;
    localparam int NB   = 4;
    localparam int ILO  = 86;
    localparam int IHI  = 89;
    localparam int AW   = 12;

    localparam int L_LEVEL = 0, L_DIR = 1, L_SET = 2, L_CLR = 3,
                   L_RISE = 4, L_FALL = 5, L_STAT = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic          bus_we;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_bank_ctrl #(
        .NUM_PINS (NP),
        .ADDR_W   (AW),
        .INV_EN   (1'b1),
        .INV_LO   (ILO),
        .INV_HI   (IHI)
    ) u_gpio_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    function automatic int addr_of(input int r, input int b);
        return r * 12 + ((b < 3) ? b * 4 : 256 + (b - 3) * 4);
    endfunction

    function automatic logic [31:0] exist_m(input int b);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = (b * 32 + i) < NP;
        return m;
    endfunction

    function automatic logic [31:0] inv_m(input int b);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = ((b * 32 + i) >= ILO) && ((b * 32 + i) <= IHI);
        return m;
    endfunction

    function automatic logic [31:0] slice(input logic [NP-1:0] v, input int b);
        logic [31:0] s;
        for (int i = 0; i < 32; i++) s[i] = ((b * 32 + i) < NP) ? v[b * 32 + i] : 1'b0;
        return s;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_raw(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = AW'(a);
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic wr(input int r, input int b, input logic [31:0] d);
        wr_raw(addr_of(r, b), d);
    endtask

    task automatic rd_raw(input int a, output logic [31:0] d);
        bus_we   = 1'b0;
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic rd(input int r, input int b, output logic [31:0] d);
        rd_raw(addr_of(r, b), d);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0]   v;
        logic [NP-1:0] exp_v;
        logic [31:0]   dirp [NB];
        logic [31:0]   outp [NB];

        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state of every register; R5 inverted pins drive after reset
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < 7; r++) begin
                rd(r, b, v);
                chk("R12 reset register", 128'(v), 128'(0));
            end
        exp_v = '0;
        for (int i = ILO; i <= IHI; i++) exp_v[i] = 1'b1;
        chk("R5 reset pin_oe", 128'(pin_oe), 128'(exp_v));
        chk("R12 reset pin_out", 128'(pin_out), 128'(0));
        chk("R9 reset irq", 128'(irq), 128'(0));

        // R4 R5 R10 direction sweep
        for (int b = 0; b < NB; b++) begin
            dirp[b] = 32'hA5C3_0F96 ^ (32'h1111_1111 * b);
            wr(L_DIR, b, dirp[b]);
            rd(L_DIR, b, v);
            chk("R10 direction readback", 128'(v), 128'(dirp[b] & exist_m(b)));
        end
        for (int i = 0; i < NP; i++) exp_v[i] = dirp[i / 32][i % 32] ^ inv_m(i / 32)[i % 32];
        chk("R4 R5 pin_oe from direction", 128'(pin_oe), 128'(exp_v));

        // R3 set and clear semantics; R11 set/clear read zero
        for (int b = 0; b < NB; b++) begin
            outp[b] = 32'h0F0F_33CC + 32'h0101_0101 * b;
            wr(L_SET, b, outp[b]);
            wr(L_CLR, b, 32'h00FF_0F00);
            outp[b] = outp[b] & ~32'h00FF_0F00;
            wr(L_SET, b, 32'h8000_0001);
            outp[b] = (outp[b] | 32'h8000_0001) & exist_m(b);
            rd(L_SET, b, v);
            chk("R11 set reads zero", 128'(v), 128'(0));
            rd(L_CLR, b, v);
            chk("R11 clear reads zero", 128'(v), 128'(0));
        end
        for (int i = 0; i < NP; i++) exp_v[i] = outp[i / 32][i % 32];
        chk("R3 pin_out after set/clear", 128'(pin_out), 128'(exp_v));

        // R2 level mixes driven outputs and synchronized inputs
        @(negedge clk);
        pin_in = {4'h9, 32'h1357_9BDF, 32'hFEDC_BA98, 32'h0246_8ACE};
        settle();
        for (int b = 0; b < NB; b++) begin
            logic [31:0] oe;
            oe = (dirp[b] ^ inv_m(b)) & exist_m(b);
            rd(L_LEVEL, b, v);
            chk("R2 mixed level", 128'(v),
                128'(((oe & outp[b]) | (~oe & slice(pin_in, b))) & exist_m(b)));
        end

        // R11 level write ignored, unmapped addresses read zero and ignore writes
        wr(L_LEVEL, 0, 32'hFFFF_FFFF);
        rd(L_LEVEL, 0, v);
        chk("R11 level write ignored", 128'(v),
            128'(((dirp[0] & outp[0]) | (~dirp[0] & slice(pin_in, 0)))));
        wr_raw(32'h054, 32'hFFFF_FFFF);
        wr_raw(32'h104, 32'hFFFF_FFFF);
        rd_raw(32'h054, v);
        chk("R11 unmapped read", 128'(v), 128'(0));
        rd_raw(32'h110, v);
        chk("R11 absent bank read", 128'(v), 128'(0));
        rd(L_DIR, 0, v);
        chk("R11 unmapped write no effect", 128'(v), 128'(dirp[0]));

        // R10 absent pins of last bank
        wr(L_RISE, 3, 32'hFFFF_FFFF);
        rd(L_RISE, 3, v);
        chk("R10 absent rise bits", 128'(v), 128'(32'h0000_000F));

        // all pins inputs, pins low, clean state
        @(negedge clk);
        pin_in = '0;
        for (int b = 0; b < NB; b++) begin
            wr(L_DIR, b, inv_m(b));
            wr(L_FALL, b, 32'h0);
        end
        settle();
        for (int b = 0; b < NB; b++) wr(L_STAT, b, 32'hFFFF_FFFF);

        // R2 two-stage latency
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(negedge clk);
        rd(L_LEVEL, 0, v);
        chk("R2 level after one edge", 128'(v), 128'(0));
        @(negedge clk);
        rd(L_LEVEL, 0, v);
        chk("R2 level after two edges", 128'(v), 128'(32'h20));
        pin_in[5] = 1'b0;
        settle();
        for (int b = 0; b < NB; b++) wr(L_STAT, b, 32'hFFFF_FFFF);

        // R6 R7 R9 R8 rising sweep over every pin
        for (int b = 0; b < NB; b++) wr(L_RISE, b, 32'hFFFF_FFFF);
        for (int p = 0; p < NP; p++) begin
            @(negedge clk);
            pin_in[p] = 1'b1;
            settle();
            rd(L_STAT, p / 32, v);
            chk("R6 rising latch", 128'(v), 128'(32'h1 << (p % 32)));
            chk("R9 irq on status", 128'(irq), 128'(1));
            pin_in[p] = 1'b0;
            settle();
            rd(L_STAT, p / 32, v);
            chk("R7 fall disabled no latch", 128'(v), 128'(32'h1 << (p % 32)));
            wr(L_STAT, p / 32, 32'h1 << (p % 32));
            rd(L_STAT, p / 32, v);
            chk("R8 single-bit clear", 128'(v), 128'(0));
            chk("R9 irq drops", 128'(irq), 128'(0));
        end

        // R7 falling sweep over every pin
        for (int b = 0; b < NB; b++) begin
            wr(L_RISE, b, 32'h0);
            wr(L_FALL, b, 32'hFFFF_FFFF);
        end
        for (int p = 0; p < NP; p++) begin
            @(negedge clk);
            pin_in[p] = 1'b1;
            settle();
            rd(L_STAT, p / 32, v);
            chk("R7 rise disabled no latch", 128'(v), 128'(0));
            pin_in[p] = 1'b0;
            settle();
            rd(L_STAT, p / 32, v);
            chk("R7 falling latch", 128'(v), 128'(32'h1 << (p % 32)));
            wr(L_STAT, p / 32, 32'h1 << (p % 32));
        end

        // R7 both enables on one pin
        wr(L_FALL, 0, 32'h8);
        wr(L_RISE, 0, 32'h8);
        @(negedge clk);
        pin_in[3] = 1'b1;
        settle();
        rd(L_STAT, 0, v);
        chk("R7 both, rising", 128'(v), 128'(32'h8));
        wr(L_STAT, 0, 32'h8);
        pin_in[3] = 1'b0;
        settle();
        rd(L_STAT, 0, v);
        chk("R7 both, falling", 128'(v), 128'(32'h8));
        wr(L_STAT, 0, 32'h8);

        // R8 write-zero keeps, partial clear, all-ones clear
        wr(L_FALL, 0, 32'h0);
        wr(L_RISE, 0, 32'h7);
        @(negedge clk);
        pin_in[2:0] = 3'b111;
        settle();
        rd(L_STAT, 0, v);
        chk("R6 three pins", 128'(v), 128'(32'h7));
        wr(L_STAT, 0, 32'h0);
        rd(L_STAT, 0, v);
        chk("R8 write zero keeps", 128'(v), 128'(32'h7));
        wr(L_STAT, 0, 32'h2);
        rd(L_STAT, 0, v);
        chk("R8 partial clear", 128'(v), 128'(32'h5));
        wr(L_STAT, 0, 32'hFFFF_FFFF);
        rd(L_STAT, 0, v);
        chk("R8 all-ones clear", 128'(v), 128'(0));

        // R8 new edge and clear in the same cycle: edge wins
        @(negedge clk);
        pin_in[0] = 1'b0;
        settle();
        pin_in[0] = 1'b1;
        settle();
        rd(L_STAT, 0, v);
        chk("R8 bit set before collision", 128'(v), 128'(32'h1));
        pin_in[0] = 1'b0;
        settle();
        pin_in[0] = 1'b1;           // toggled on a falling edge
        @(negedge clk);             // first rising edge passed
        @(negedge clk);             // second rising edge passed
        bus_addr  = AW'(addr_of(L_STAT, 0));
        bus_wdata = 32'h1;
        bus_we    = 1'b1;           // write lands on the third rising edge
        @(negedge clk);
        bus_we    = 1'b0;
        rd(L_STAT, 0, v);
        chk("R8 edge beats clear", 128'(v), 128'(32'h1));
        wr(L_STAT, 0, 32'h1);
        rd(L_STAT, 0, v);
        chk("R8 clear without edge", 128'(v), 128'(0));
        chk("R9 irq idle at end", 128'(irq), 128'(0));

        // R1 address arithmetic: distinct banks hold distinct values
        for (int b = 0; b < NB; b++) wr(L_FALL, b, 32'h10 << b);
        for (int b = 0; b < NB; b++) begin
            rd_raw(60 + ((b < 3) ? b * 4 : 256 + (b - 3) * 4), v);
            chk("R1 bank address map", 128'(v), 128'((32'h10 << b) & exist_m(b)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule